// File: doc/BRIEF.md
# Subranging Converter Digital Correction

This block sits behind a three-stage subranging analog-to-digital converter and turns the stage decisions into one corrected sample word. The coarse stage resolves 5 bits, the middle stage 5 bits and the fine stage 6 bits. Each stage takes its sample at a different moment, so each decision arrives on its own strobe, a fixed number of cycles after the coarse one. The block delays the earlier decisions until all three belong to the same sample. It then adds them with a one-bit overlap at each stage boundary, so 16 raw bits give a 14-bit word.

The overlap bit lets a later stage absorb a wrong decision in the stage before it. The merge removes a fixed offset of half an overlap step per boundary. As long as an error stays inside that redundancy, the corrected word equals the ideal code. A sum below zero or above full scale is clamped to the nearest rail and flagged. The corrected word is registered and appears three cycles after the coarse strobe.

Top module: `subrange_corrector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `res_vld`, `res_code` and `res_clip` are all zero.
- R2: With the defaults (middle strobe one cycle after the coarse strobe, fine strobe two cycles after it), `res_vld` is high for exactly one cycle, three cycles after the coarse strobe. It is low in the two cycles before that.
- R3: The corrected value is coarse*512 + mid*32 + fine − 272. Each code is taken as an unsigned integer. The coarse code is weighted at bit 9, the middle code at bit 5 and the fine code at bit 0.
- R4: For any ideal 14-bit code, the corrected word equals the ideal code in two cases. The coarse decision may be off by up to half a coarse step (256 output LSB) in either direction. The middle decision may be off by up to half a middle step (16 output LSB). In both cases the later stage carries the residue plus its mid-scale offset.
- R5: A corrected value below zero gives `res_code` = 0 with `res_clip` = 1.
- R6: A corrected value above 16383 gives `res_code` = 16383 with `res_clip` = 1.
- R7: A corrected value within 0..16383, the two rails included, gives `res_clip` = 0.
- R8: If the middle strobe or the fine strobe does not arrive in its slot after a coarse strobe, that sample produces no `res_vld` pulse.
- R9: While `res_vld` is low, `res_code` and `res_clip` keep their last values, whatever the stage code inputs carry.
- R10: A new sample can start on every cycle. Overlapping samples each produce one result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| crs_code | input | 5 | Coarse stage decision |
| crs_vld | input | 1 | Coarse decision strobe |
| mid_code | input | 5 | Middle stage decision |
| mid_vld | input | 1 | Middle decision strobe |
| fin_code | input | 6 | Fine stage decision |
| fin_vld | input | 1 | Fine decision strobe |
| res_code | output | 14 | Corrected, clamped sample |
| res_clip | output | 1 | Clamp flag for the current result |
| res_vld | output | 1 | Result strobe |

## Verification
A wrong delay in one alignment line pairs the decisions of neighbouring samples. In a dense stream this shows on the very next result as a code off by a multiple of 32 or 512. A lost strobe in the alignment path shows within three cycles, as a missing or extra `res_vld` pulse. An error in the offset or the weights moves the result away from the ideal code on nearly every sample of the sweep. A wrong compare in the clamp shows at the rails, as a wrapped code or a wrong `res_clip`, in the same cycle as the result.

// File: rtl/subrange_pkg.sv
// Shared types for the subranging correction block.
// Assumes: nothing beyond plain SystemVerilog.
package subrange_pkg;

    // Outcome of the range check on a merged sum
    typedef enum logic [1:0] {
        RNG_IN   = 2'd0,
        RNG_UNDER = 2'd1,
        RNG_OVER  = 2'd2
    } rng_e;

endpackage

// File: rtl/stage_align.sv
// Fixed-depth delay line for one stage decision and its strobe.
// Assumes: DEPTH >= 1. The line shifts every cycle, so a decision leaves
// it exactly DEPTH cycles after it was sampled.
module stage_align #(
    parameter int W     = 5,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         vin,
    output logic [W-1:0] dout,
    output logic         vout
);

    logic [W-1:0] code_q [DEPTH];
    logic         vld_q  [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_tap
            if (i == 0) begin : g_head
                // First tap: capture the stage input
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        code_q[i] <= '0;
                        vld_q[i]  <= 1'b0;
                    end else begin
                        code_q[i] <= din;
                        vld_q[i]  <= vin;
                    end
                end
            end else begin : g_body
                // Later taps: move the previous tap forward
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        code_q[i] <= '0;
                        vld_q[i]  <= 1'b0;
                    end else begin
                        code_q[i] <= code_q[i-1];
                        vld_q[i]  <= vld_q[i-1];
                    end
                end
            end
        end
    endgenerate

    assign dout = code_q[DEPTH-1];
    assign vout = vld_q[DEPTH-1];

endmodule

// File: rtl/code_merge.sv
// Weighted sum of three aligned stage decisions with the redundancy offset removed.
// Assumes: each later stage's MSB overlaps the previous stage's LSB by one bit,
// and each later stage is centred by half of its range (its mid-scale offset).
module code_merge #(
    parameter int C_W   = 5,
    parameter int M_W   = 5,
    parameter int F_W   = 6,
    parameter int SUM_W = 16
) (
    input  logic [C_W-1:0]          c_code,
    input  logic [M_W-1:0]          m_code,
    input  logic [F_W-1:0]          f_code,
    output logic signed [SUM_W-1:0] sum
);

    localparam int SH_M = F_W - 1;
    localparam int SH_C = SH_M + M_W - 1;
    localparam int OFS  = (1 << (SH_M + M_W - 2)) + (1 << (F_W - 2));

    logic signed [SUM_W-1:0] c_term, m_term, f_term;

    // Place each decision at its weight and subtract the combined offset
    always_comb begin
        c_term = $signed(SUM_W'(c_code)) <<< SH_C;
        m_term = $signed(SUM_W'(m_code)) <<< SH_M;
        f_term = $signed(SUM_W'(f_code));
        sum    = c_term + m_term + f_term - $signed(SUM_W'(OFS));
    end

endmodule

// File: rtl/range_clamp.sv
// Saturates a signed merged sum to the unsigned output range.
// Assumes: SUM_W > OUT_W + 1, so every sum fits without wrap.
module range_clamp
    import subrange_pkg::*;
#(
    parameter int SUM_W = 16,
    parameter int OUT_W = 14
) (
    input  logic signed [SUM_W-1:0] sum,
    output logic [OUT_W-1:0]        code,
    output rng_e                    rng
);

    localparam logic signed [SUM_W-1:0] TOP = $signed(SUM_W'((1 << OUT_W) - 1));

    // Pick the rail or pass the sum, and report which one was taken
    always_comb begin
        if (sum < 0) begin
            code = '0;
            rng  = RNG_UNDER;
        end else if (sum > TOP) begin
            code = '1;
            rng  = RNG_OVER;
        end else begin
            code = sum[OUT_W-1:0];
            rng  = RNG_IN;
        end
    end

endmodule

// File: rtl/subrange_corrector.sv
// Top of the correction block: aligns three stage decisions, merges and clamps them.
// Assumes: the middle strobe follows the coarse strobe by MID_LAG cycles and the
// fine strobe by FIN_LAG cycles, with FIN_LAG >= MID_LAG. The result appears
// FIN_LAG + 1 cycles after the coarse strobe.
module subrange_corrector
    import subrange_pkg::*;
#(
    parameter int C_W     = 5,
    parameter int M_W     = 5,
    parameter int F_W     = 6,
    parameter int MID_LAG = 1,
    parameter int FIN_LAG = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [C_W-1:0]               crs_code,
    input  logic                         crs_vld,
    input  logic [M_W-1:0]               mid_code,
    input  logic                         mid_vld,
    input  logic [F_W-1:0]               fin_code,
    input  logic                         fin_vld,
    output logic [C_W+M_W+F_W-3:0]       res_code,
    output logic                         res_clip,
    output logic                         res_vld
);

    localparam int OUT_W = C_W + M_W + F_W - 2;
    localparam int SUM_W = OUT_W + 2;
    localparam int C_DEP = FIN_LAG + 1;
    localparam int M_DEP = FIN_LAG - MID_LAG + 1;
    localparam int F_DEP = 1;

    logic [C_W-1:0]          c_al;
    logic [M_W-1:0]          m_al;
    logic [F_W-1:0]          f_al;
    logic                    c_v, m_v, f_v;
    logic signed [SUM_W-1:0] sum;
    logic [OUT_W-1:0]        clamped;
    rng_e                    rng;
    logic                    take;

    stage_align #(.W(C_W), .DEPTH(C_DEP)) u_crs (
        .clk(clk), .rst_n(rst_n), .din(crs_code), .vin(crs_vld),
        .dout(c_al), .vout(c_v)
    );

    stage_align #(.W(M_W), .DEPTH(M_DEP)) u_mid (
        .clk(clk), .rst_n(rst_n), .din(mid_code), .vin(mid_vld),
        .dout(m_al), .vout(m_v)
    );

    stage_align #(.W(F_W), .DEPTH(F_DEP)) u_fin (
        .clk(clk), .rst_n(rst_n), .din(fin_code), .vin(fin_vld),
        .dout(f_al), .vout(f_v)
    );

    code_merge #(.C_W(C_W), .M_W(M_W), .F_W(F_W), .SUM_W(SUM_W)) u_merge (
        .c_code(c_al), .m_code(m_al), .f_code(f_al), .sum(sum)
    );

    range_clamp #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_clamp (
        .sum(sum), .code(clamped), .rng(rng)
    );

    // A result exists only when all three decisions of one sample are aligned
    assign take = c_v & m_v & f_v;

    // Output register: load on a complete sample, otherwise hold the last result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_code <= '0;
            res_clip <= 1'b0;
            res_vld  <= 1'b0;
        end else begin
            res_vld <= take;
            if (take) begin
                res_code <= clamped;
                res_clip <= (rng != RNG_IN);
            end
        end
    end

endmodule

// File: rtl/subrange_corrector_chk.sv
// Property checker for subrange_corrector, attached with bind.
// Assumes the default strobe lags (middle +1, fine +2).
module subrange_corrector_chk #(
    parameter int OUT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             crs_vld,
    input logic             mid_vld,
    input logic             fin_vld,
    input logic [OUT_W-1:0] res_code,
    input logic             res_clip,
    input logic             res_vld
);

    logic [1:0] seen;

    // Count clocks since reset, saturating at three
    always_ff @(posedge clk) begin
        if (!rst_n)          seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    // R2
    lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && $past(crs_vld, 3) && $past(mid_vld, 2) && $past(fin_vld, 1))
        |=> res_vld);

    // R8
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && !($past(mid_vld, 2) && $past(fin_vld, 1))) |=> !res_vld);

    // R6
    rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_clip) |-> (res_code == '0 || res_code == '1));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && !res_vld) |-> ($stable(res_code) && $stable(res_clip)));

endmodule

bind subrange_corrector subrange_corrector_chk #(.OUT_W(C_W + M_W + F_W - 2)) u_chk (
    .clk(clk), .rst_n(rst_n), .crs_vld(crs_vld), .mid_vld(mid_vld),
    .fin_vld(fin_vld), .res_code(res_code), .res_clip(res_clip), .res_vld(res_vld)
);

// File: tb/sim_subrange_corrector.sv
module sim_subrange_corrector;

    localparam int CLK_PER = 10;
    localparam int NSAMP   = 16384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  crs_code = '0, mid_code = '0;
    logic [5:0]  fin_code = '0;
    logic        crs_vld = 1'b0, mid_vld = 1'b0, fin_vld = 1'b0;
    logic [13:0] res_code;
    logic        res_clip, res_vld;

    int n_chk = 0;
    int n_bad = 0;
    int mon_idx = 0;
    int pass_no = 0;
    bit mon_en = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    subrange_corrector u0 (
        .clk(clk), .rst_n(rst_n),
        .crs_code(crs_code), .crs_vld(crs_vld),
        .mid_code(mid_code), .mid_vld(mid_vld),
        .fin_code(fin_code), .fin_vld(fin_vld),
        .res_code(res_code), .res_clip(res_clip), .res_vld(res_vld)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Models the three stage decisions of ideal code d with bounded threshold errors
    function automatic void gen(input int pass, input int idx,
                                output int c, output int m, output int f, output int d);
        int n1, n2, x, r1, y;
        d = idx;
        if (pass == 0) begin
            n1 = ((idx * 37) % 512) - 256;
            n2 = ((idx * 13) % 32) - 16;
        end else begin
            n1 = (idx % 2 == 1) ? 255 : -256;
            n2 = (idx % 3 == 0) ? -16 : ((idx % 3 == 1) ? 15 : 0);
        end
        x = d + n1;
        c = (x < 0) ? 0 : x / 512;
        if (c > 31) c = 31;
        r1 = d - c * 512 + 256;
        y = r1 + n2;
        m = (y < 0) ? 0 : y / 32;
        if (m > 31) m = 31;
        f = r1 - m * 32 + 16;
    endfunction

    // Stream monitor: compares every result of a sweep with the ideal code (R4, R3)
    always @(negedge clk) begin
        if (mon_en && res_vld) begin
            int c, m, f, d;
            gen(pass_no, mon_idx, c, m, f, d);
            chk("R4 sweep code", int'(res_code), d);
            chk("R7 sweep clip", int'(res_clip), 0);
            mon_idx++;
        end
    end

    // Streams NSAMP overlapping samples, one new sample per cycle (R10)
    task automatic run_sweep(input int pass);
        pass_no = pass;
        mon_idx = 0;
        mon_en  = 1'b1;
        for (int j = 0; j < NSAMP + 2; j++) begin
            int c, m, f, d;
            @(posedge clk); #1;
            crs_vld = 1'b0; mid_vld = 1'b0; fin_vld = 1'b0;
            if (j < NSAMP) begin
                gen(pass, j, c, m, f, d);
                crs_code = 5'(c); crs_vld = 1'b1;
            end
            if (j >= 1 && j - 1 < NSAMP) begin
                gen(pass, j - 1, c, m, f, d);
                mid_code = 5'(m); mid_vld = 1'b1;
            end
            if (j >= 2) begin
                gen(pass, j - 2, c, m, f, d);
                fin_code = 6'(f); fin_vld = 1'b1;
            end
        end
        @(posedge clk); #1;
        crs_vld = 1'b0; mid_vld = 1'b0; fin_vld = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        mon_en = 1'b0;
        chk("R10 result count", mon_idx, NSAMP);
    endtask

    // One sample with optional missing strobes; checks the cycle of the result
    task automatic send_one(input int c, input int m, input int f,
                            input bit use_m, input bit use_f,
                            input bit exp_v, input int exp_code, input int exp_clip,
                            input string req);
        @(posedge clk); #1;
        crs_code = 5'(c); crs_vld = 1'b1;
        @(posedge clk); #1;
        crs_vld = 1'b0; mid_code = 5'(m); mid_vld = use_m;
        @(posedge clk); #1;
        mid_vld = 1'b0; fin_code = 6'(f); fin_vld = use_f;
        @(posedge clk); #1;
        fin_vld = 1'b0;
        @(negedge clk);
        chk({req, " R2 no early valid"}, int'(res_vld), 0);
        @(negedge clk);
        chk({req, " valid at latency 3"}, int'(res_vld), int'(exp_v));
        if (exp_v) begin
            chk({req, " code"}, int'(res_code), exp_code);
            chk({req, " clip"}, int'(res_clip), exp_clip);
        end
        @(negedge clk);
        chk({req, " R2 single pulse"}, int'(res_vld), 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset valid", int'(res_vld), 0);
        chk("R1 reset code", int'(res_code), 0);
        chk("R1 reset clip", int'(res_clip), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle valid", int'(res_vld), 0);

        // R3: weighted merge of plain codes
        send_one(10, 17, 33, 1, 1, 1, 10*512 + 17*32 + 33 - 272, 0, "R3 mid-range");
        send_one(0, 8, 16, 1, 1, 1, 0, 0, "R7 exact zero");
        send_one(31, 23, 47, 1, 1, 1, 16383, 0, "R7 exact top");
        send_one(0, 8, 15, 1, 1, 1, 0, 1, "R5 one below zero");
        send_one(0, 0, 0, 1, 1, 1, 0, 1, "R5 deepest under");
        send_one(31, 23, 48, 1, 1, 1, 16383, 1, "R6 one above top");
        send_one(31, 31, 63, 1, 1, 1, 16383, 1, "R6 highest over");

        // R8: incomplete samples produce nothing
        send_one(5, 5, 5, 0, 1, 0, 0, 0, "R8 no middle strobe");
        send_one(5, 5, 5, 1, 0, 0, 0, 0, "R8 no fine strobe");

        // R9: codes wiggle without strobes, the result holds
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            crs_code = 5'(k * 7); mid_code = 5'(k * 3); fin_code = 6'(k * 11);
        end
        @(negedge clk);
        chk("R9 held code", int'(res_code), 16383);
        chk("R9 held clip", int'(res_clip), 1);

        run_sweep(0);
        run_sweep(1);

        // R1: reset in mid-run clears the result
        send_one(12, 16, 32, 1, 1, 1, 12*512 + 16*32 + 32 - 272, 0, "R3 before reset");
        @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        chk("R1 mid-run code", int'(res_code), 0);
        chk("R1 mid-run valid", int'(res_vld), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule